// File: doc/BRIEF.md
# Parallel-ATA Host Event and DMA Status Unit

This block gathers the interrupt events of a parallel-ATA host controller into one register set and drives a single interrupt line to the processor. Eight one-cycle event pulses come in from the transfer engine, the device interrupt pin and the bus interface. They are latched as status bits, masked one by one, and ORed into a registered interrupt request. Beside the event register sit a DMA command byte and a DMA status byte. The command byte starts and stops the transfer engine and sets its direction. The status byte reports activity, errors and completion, and holds two per-drive capability flags.

Software reaches the block through a small synchronous register bus. It has a write port with two byte enables and a separate combinational read port. A system control halfword issues a soft reset, which clears the event, mask and DMA state, and a FIFO reset, each as a one-cycle pulse. It also shows the cable type. Completion is tracked by a three-state machine. DM_IDLE goes to DM_RUN on a start write. DM_RUN goes to DM_HALF when exactly one of transfer end and device interrupt has been recorded, and goes back to DM_RUN when neither is recorded. DM_RUN and DM_HALF go back to DM_IDLE in three cases: both completion events are recorded, a stop write arrives, or a soft reset applies. A start write while running re-enters DM_RUN.

Clearing the DMA interrupt flag has side effects in the event register. It wipes every mask bit and clears the transfer-end and device-interrupt status bits in the same write.

Top module: `pata_evt_unit`

## Requirements
- R1: Event pulse `evt_i[k]` sets event status bit k. Bit 7 = address error, 6 = reach-multiple, 5 = device timing error, 4 = UDMA terminate, 3 = timer, 2 = bus error, 1 = transfer end, 0 = device interrupt. An event and a write-1-to-clear on the same bit in the same cycle leave the bit set.
- R2: A write to the low byte of the event register (address 1, byte enable 0) clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R3: The high byte of the event register (address 1, byte enable 1) holds the mask bits. Mask bit k+8 masks status bit k. The byte is written directly and reads back as written.
- R4: `irq_o` is registered. In each cycle it equals the OR over k of (status k AND NOT mask k) as held in the previous cycle.
- R5: DMA command byte (address 2, low byte) keeps bits 0 and 3 and reads all other bits as 0. Writing bit 0 = 1 starts the engine: `dma_run_o` and DMA status bit 0 go to 1 in the next cycle. Writing bit 0 = 0 stops it. Bit 3 drives `dma_dir_o` (1 = device to memory).
- R6: While the engine runs, once transfer end (bit 1) and device interrupt (bit 0) are both held in the event register, the next edge sets DMA status bit 2 and clears bit 0. With only one of them held, the engine keeps running.
- R7: Writing 1 to DMA status bit 2 (address 2, high byte, data bit 10) clears that flag, all eight mask bits, and event status bits 1 and 0. Other status bits are kept.
- R8: A bus-error event also sets DMA status bit 1. Writing 1 to it (data bit 9) clears it and leaves event status bit 2 unchanged.
- R9: DMA status bits 5 and 6 (data bits 13 and 14) are plain read/write flags.
- R10: System control (address 0, high byte). Writing bit 15 = 1 holds the block in soft reset while the bit stays 1, zeroing event, mask and DMA state, and gives `soft_rst_o` one cycle high after a 0-to-1 change. Bit 14 gives `fifo_rst_o` the same kind of pulse. Bit 13 reads `cable_40w_i`. All other bits read as 0.
- R11: After `rst_n` all registers read 0, except the cable bit. `irq_o`, `dma_run_o`, `dma_dir_o` and both pulses are low.
- R12: Read address 2 returns {DMA status, DMA command}. Read address 3 returns 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Write halfword address |
| reg_be_i | input | 2 | Write byte enables |
| reg_wdata_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read halfword address |
| rd_data_o | output | 16 | Read data, combinational |
| evt_i | input | 8 | One-cycle event pulses |
| cable_40w_i | input | 1 | Cable indicator, 1 = 40-wire |
| irq_o | output | 1 | Interrupt request |
| dma_run_o | output | 1 | DMA engine run control |
| dma_dir_o | output | 1 | DMA direction, 1 = device to memory |
| fifo_rst_o | output | 1 | FIFO reset pulse |
| soft_rst_o | output | 1 | Soft reset pulse |

## Verification
Assertions check several rules on every cycle. An event outranks a clear on the same bit. A DMA interrupt clear empties the mask byte. A bus error lands in the DMA error flag. A completion raises the DMA interrupt flag and drops the run state. Soft reset zeroes the event and DMA state, and the reset pulses last a single cycle. Some behaviour only the bench scenarios can show. These cover the exact read-back layout of every register, the one-cycle lag of the interrupt line, a run that waits in the half-complete state for its second event, and byte-lane selectivity under random traffic.

// File: rtl/pev_pkg.sv
`timescale 1ns/100ps
package pev_pkg;
    localparam int EVT_W  = 8;
    localparam int REG_W  = 2 * EVT_W;

    // event status bit positions
    localparam int EV_HOST   = 0;
    localparam int EV_XEND   = 1;
    localparam int EV_BUSERR = 2;

    // dma status bit positions
    localparam int DS_ACT  = 0;
    localparam int DS_ERR  = 1;
    localparam int DS_INT  = 2;
    localparam int DS_CAPL = 5;
    localparam int DS_CAPH = 6;

    // dma command bit positions
    localparam int CM_GO  = 0;
    localparam int CM_DIR = 3;

    // system control bit positions
    localparam int SC_SRST  = 15;
    localparam int SC_FRST  = 14;
    localparam int SC_CABLE = 13;

    localparam logic [1:0] RA_SYS = 2'd0;
    localparam logic [1:0] RA_EVT = 2'd1;
    localparam logic [1:0] RA_DMA = 2'd2;

    typedef enum logic [1:0] {
        DM_IDLE = 2'd0,
        DM_RUN  = 2'd1,
        DM_HALF = 2'd2
    } dma_st_e;
endpackage

// File: rtl/pev_sysctl.sv
`timescale 1ns/100ps
module pev_sysctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_wr_i,
    input  logic srst_bit_i,
    input  logic frst_bit_i,
    output logic srst_q_o,
    output logic frst_q_o,
    output logic srst_now_o,
    output logic soft_rst_o,
    output logic fifo_rst_o
);
    logic srst_q, frst_q, spulse_q, fpulse_q;
    logic srst_set, frst_set;

    assign srst_set = hi_wr_i & srst_bit_i;
    assign frst_set = hi_wr_i & frst_bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q   <= 1'b0;
            frst_q   <= 1'b0;
            spulse_q <= 1'b0;
            fpulse_q <= 1'b0;
        end else begin
            if (hi_wr_i) begin
                srst_q <= srst_bit_i;
                frst_q <= frst_bit_i;
            end
            spulse_q <= srst_set & ~srst_q;
            fpulse_q <= frst_set & ~frst_q;
        end
    end

    assign srst_q_o   = srst_q;
    assign frst_q_o   = frst_q;
    assign srst_now_o = srst_q | srst_set;
    assign soft_rst_o = spulse_q;
    assign fifo_rst_o = fpulse_q;

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o); // R10
    AST_FRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_o |=> !fifo_rst_o); // R10
endmodule

// File: rtl/pev_intctl.sv
`timescale 1ns/100ps
module pev_intctl #(
    parameter int EVT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst_i,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic               w1c_wr_i,
    input  logic               mask_wr_i,
    input  logic [2*EVT_W-1:0] wdata_i,
    input  logic               dclr_i,
    output logic [EVT_W-1:0]   status_o,
    output logic [EVT_W-1:0]   mask_o,
    output logic               irq_o
);
    logic [EVT_W-1:0] status_q, status_n, mask_q, mask_n;
    logic             irq_q;

    for (genvar g = 0; g < EVT_W; g++) begin : g_bit
        localparam bit DMA_LINKED = (g == pev_pkg::EV_HOST) || (g == pev_pkg::EV_XEND);
        logic clr;
        assign clr = (w1c_wr_i & wdata_i[g]) | (dclr_i & DMA_LINKED);
        // a new event outranks any clear on the same bit
        assign status_n[g] = evt_i[g] | (status_q[g] & ~clr);
    end

    always_comb begin
        mask_n = mask_q;
        if (mask_wr_i)
            mask_n = wdata_i[2*EVT_W-1:EVT_W];
        else if (dclr_i)
            mask_n = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= |(status_q & ~mask_q);
            if (srst_i) begin
                status_q <= '0;
                mask_q   <= '0;
            end else begin
                status_q <= status_n;
                mask_q   <= mask_n;
            end
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = irq_q;

    AST_EVT_OUTRANKS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_i) && !srst_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R1
    AST_DCLR_WIPES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (dclr_i && !srst_i && !mask_wr_i) |=> (mask_q == '0)); // R7
    AST_SRST_ZEROES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (status_q == '0 && mask_q == '0)); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> !irq_o); // R4
endmodule

// File: rtl/pev_dmactl.sv
`timescale 1ns/100ps
module pev_dmactl
    import pev_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srst_i,
    input  logic       cmd_wr_i,
    input  logic       cmd_go_i,
    input  logic       cmd_dir_i,
    input  logic       stat_wr_i,
    input  logic       clr_err_i,
    input  logic       clr_int_i,
    input  logic [1:0] cap_i,
    input  logic       rec_xend_i,
    input  logic       rec_host_i,
    input  logic       buserr_i,
    output logic [7:0] cmd_o,
    output logic [7:0] stat_o,
    output logic       run_o,
    output logic       dir_o
);
    dma_st_e    state_q, state_n;
    logic       done;
    logic       go_q, dir_q, err_q, int_q;
    logic [1:0] cap_q;

    assign done = (state_q != DM_IDLE) & rec_xend_i & rec_host_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DM_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (srst_i) begin
            state_n = DM_IDLE;
        end else begin
            unique case (state_q)
                DM_IDLE: begin
                    if (cmd_wr_i && cmd_go_i) state_n = DM_RUN;
                end
                DM_RUN, DM_HALF: begin
                    if (cmd_wr_i)                    state_n = cmd_go_i ? DM_RUN : DM_IDLE;
                    else if (done)                   state_n = DM_IDLE;
                    else if (rec_xend_i ^ rec_host_i) state_n = DM_HALF;
                    else                             state_n = DM_RUN;
                end
                default: state_n = DM_IDLE;
            endcase
        end
    end

    // output and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            err_q <= 1'b0;
            int_q <= 1'b0;
            cap_q <= '0;
        end else if (srst_i) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            err_q <= 1'b0;
            int_q <= 1'b0;
            cap_q <= '0;
        end else begin
            if (cmd_wr_i) begin
                go_q  <= cmd_go_i;
                dir_q <= cmd_dir_i;
            end
            err_q <= buserr_i | (err_q & ~(stat_wr_i & clr_err_i));
            int_q <= done | (int_q & ~(stat_wr_i & clr_int_i));
            if (stat_wr_i) cap_q <= cap_i;
        end
    end

    assign run_o = (state_q != DM_IDLE);
    assign dir_o = dir_q;

    always_comb begin
        cmd_o          = '0;
        cmd_o[CM_GO]   = go_q;
        cmd_o[CM_DIR]  = dir_q;
        stat_o          = '0;
        stat_o[DS_ACT]  = run_o;
        stat_o[DS_ERR]  = err_q;
        stat_o[DS_INT]  = int_q;
        stat_o[DS_CAPL] = cap_q[0];
        stat_o[DS_CAPH] = cap_q[1];
    end

    AST_DONE_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !srst_i && !(cmd_wr_i && cmd_go_i)) |=> (stat_o[DS_INT] && !run_o)); // R6
    AST_BUSERR_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (buserr_i && !srst_i) |=> stat_o[DS_ERR]); // R8
    AST_SRST_IDLES_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (state_q == DM_IDLE && stat_o == '0 && cmd_o == '0)); // R10
    AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !cmd_go_i) |=> !run_o); // R5
endmodule

// File: rtl/pata_evt_unit.sv
`timescale 1ns/100ps
module pata_evt_unit
    import pev_pkg::*;
#(
    parameter int EVT_W = pev_pkg::EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [1:0]         reg_be_i,
    input  logic [2*EVT_W-1:0] reg_wdata_i,
    input  logic [1:0]         rd_addr_i,
    output logic [2*EVT_W-1:0] rd_data_o,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic               cable_40w_i,
    output logic               irq_o,
    output logic               dma_run_o,
    output logic               dma_dir_o,
    output logic               fifo_rst_o,
    output logic               soft_rst_o
);
    localparam int RW = 2 * EVT_W;

    logic sys_hi_wr, evt_lo_wr, evt_hi_wr, dma_lo_wr, dma_hi_wr;
    logic srst_q, frst_q, srst_now;
    logic [EVT_W-1:0] ev_status, ev_mask;
    logic [7:0] dma_cmd, dma_stat;

    assign sys_hi_wr = reg_wr_i & (reg_addr_i == RA_SYS) & reg_be_i[1];
    assign evt_lo_wr = reg_wr_i & (reg_addr_i == RA_EVT) & reg_be_i[0];
    assign evt_hi_wr = reg_wr_i & (reg_addr_i == RA_EVT) & reg_be_i[1];
    assign dma_lo_wr = reg_wr_i & (reg_addr_i == RA_DMA) & reg_be_i[0];
    assign dma_hi_wr = reg_wr_i & (reg_addr_i == RA_DMA) & reg_be_i[1];

    pev_sysctl u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_wr_i    (sys_hi_wr),
        .srst_bit_i (reg_wdata_i[SC_SRST]),
        .frst_bit_i (reg_wdata_i[SC_FRST]),
        .srst_q_o   (srst_q),
        .frst_q_o   (frst_q),
        .srst_now_o (srst_now),
        .soft_rst_o (soft_rst_o),
        .fifo_rst_o (fifo_rst_o)
    );

    pev_intctl #(.EVT_W(EVT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst_now),
        .evt_i     (evt_i),
        .w1c_wr_i  (evt_lo_wr),
        .mask_wr_i (evt_hi_wr),
        .wdata_i   (reg_wdata_i),
        .dclr_i    (dma_hi_wr & reg_wdata_i[8 + DS_INT]),
        .status_o  (ev_status),
        .mask_o    (ev_mask),
        .irq_o     (irq_o)
    );

    pev_dmactl u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (srst_now),
        .cmd_wr_i   (dma_lo_wr),
        .cmd_go_i   (reg_wdata_i[CM_GO]),
        .cmd_dir_i  (reg_wdata_i[CM_DIR]),
        .stat_wr_i  (dma_hi_wr),
        .clr_err_i  (reg_wdata_i[8 + DS_ERR]),
        .clr_int_i  (reg_wdata_i[8 + DS_INT]),
        .cap_i      (reg_wdata_i[8 + DS_CAPH : 8 + DS_CAPL]),
        .rec_xend_i (ev_status[EV_XEND]),
        .rec_host_i (ev_status[EV_HOST]),
        .buserr_i   (evt_i[EV_BUSERR]),
        .cmd_o      (dma_cmd),
        .stat_o     (dma_stat),
        .run_o      (dma_run_o),
        .dir_o      (dma_dir_o)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            RA_SYS: begin
                rd_data_o[SC_SRST]  = srst_q;
                rd_data_o[SC_FRST]  = frst_q;
                rd_data_o[SC_CABLE] = cable_40w_i;
            end
            RA_EVT:  rd_data_o = {ev_mask, ev_status};
            RA_DMA:  rd_data_o = {{(RW-16){1'b0}}, dma_stat, dma_cmd};
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: tb/pata_evt_unit_tb.sv
`timescale 1ns/100ps
module pata_evt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [1:0]  reg_be_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [1:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic [7:0]  evt_i = '0;
    logic        cable_40w_i = 1'b0;
    logic        irq_o, dma_run_o, dma_dir_o, fifo_rst_o, soft_rst_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state
    logic [7:0] m_status = '0, m_mask = '0, m_cmd = '0;
    logic       m_act = 0, m_err = 0, m_int = 0, m_srst = 0, m_frst = 0;
    logic [1:0] m_cap = '0;
    logic       m_irq = 0, m_sp = 0, m_fp = 0;

    always #5 clk = ~clk;

    pata_evt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .evt_i(evt_i), .cable_40w_i(cable_40w_i),
        .irq_o(irq_o), .dma_run_o(dma_run_o), .dma_dir_o(dma_dir_o),
        .fifo_rst_o(fifo_rst_o), .soft_rst_o(soft_rst_o)
    );

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_srst, m_frst, cable_40w_i, 13'b0};
            2'd1: return {m_mask, m_status};
            2'd2: return {1'b0, m_cap, 2'b00, m_int, m_err, m_act, m_cmd};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic cmp(input logic [15:0] act, input logic [15:0] expv, input string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic rdchk(input logic [1:0] a, input logic [15:0] expv, input string tag);
        rd_addr_i = a;
        #0.2;
        cmp(rd_data_o, expv, tag);
    endtask

    // one clock cycle with given bus and event inputs; model advanced in step
    task automatic tick(input logic wr, input logic [1:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input logic [7:0] ev);
        logic srst_w, frst_w, sact, cmdwr, stwr, dclr, done, sysw;
        logic [7:0] w1c, ns, nm, ncmd;
        logic nact, nint, nerr, nsrst, nfrst, nirq, nsp, nfp;
        logic [1:0] ncap;
        reg_wr_i = wr; reg_addr_i = a; reg_be_i = be; reg_wdata_i = wd; evt_i = ev;
        sysw   = wr && a == 2'd0 && be[1];
        srst_w = sysw && wd[15];
        frst_w = sysw && wd[14];
        sact   = m_srst || srst_w;
        nirq   = |(m_status & ~m_mask);
        nsp    = srst_w && !m_srst;
        nfp    = frst_w && !m_frst;
        nsrst  = sysw ? wd[15] : m_srst;
        nfrst  = sysw ? wd[14] : m_frst;
        cmdwr  = wr && a == 2'd2 && be[0];
        stwr   = wr && a == 2'd2 && be[1];
        dclr   = stwr && wd[10];
        w1c    = (wr && a == 2'd1 && be[0]) ? wd[7:0] : 8'h00;
        ns     = (m_status & ~w1c & ~(dclr ? 8'h03 : 8'h00)) | ev;
        nm     = (wr && a == 2'd1 && be[1]) ? wd[15:8] : (dclr ? 8'h00 : m_mask);
        done   = m_act && m_status[1] && m_status[0];
        nact   = cmdwr ? wd[0] : (m_act && !done);
        nint   = (m_int && !(stwr && wd[10])) || done;
        nerr   = (m_err && !(stwr && wd[9])) || ev[2];
        ncap   = stwr ? wd[14:13] : m_cap;
        ncmd   = cmdwr ? (wd[7:0] & 8'h09) : m_cmd;
        if (sact) begin
            ns = 0; nm = 0; nact = 0; nint = 0; nerr = 0; ncap = 0; ncmd = 0;
        end
        @(posedge clk);
        @(negedge clk);
        m_status = ns; m_mask = nm; m_cmd = ncmd; m_act = nact; m_err = nerr;
        m_int = nint; m_cap = ncap; m_srst = nsrst; m_frst = nfrst;
        m_irq = nirq; m_sp = nsp; m_fp = nfp;
        reg_wr_i = 1'b0; evt_i = '0;
        cmp({15'b0, irq_o}, {15'b0, m_irq}, "R4 irq");
        cmp({15'b0, dma_run_o}, {15'b0, m_act}, "R5 run");
        cmp({15'b0, dma_dir_o}, {15'b0, m_cmd[3]}, "R5 dir");
        cmp({15'b0, soft_rst_o}, {15'b0, m_sp}, "R10 soft pulse");
        cmp({15'b0, fifo_rst_o}, {15'b0, m_fp}, "R10 fifo pulse");
        for (int k = 0; k < 4; k++) begin
            rd_addr_i = k[1:0];
            #0.2;
            cmp(rd_data_o, exp_rd(k[1:0]), k == 0 ? "R10 sysctl" : k == 1 ? "R1 evt reg" :
                k == 2 ? "R6 dma regs" : "R12 unmapped");
        end
    endtask

    task automatic idle();
        tick(1'b0, 2'd0, 2'b00, 16'h0000, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4939));
        @(negedge clk); @(negedge clk);
        // R11: reset state
        rdchk(2'd0, 16'h0000, "R11 sysctl reset");
        rdchk(2'd1, 16'h0000, "R11 evt reset");
        rdchk(2'd2, 16'h0000, "R11 dma reset");
        cmp({15'b0, irq_o}, 16'h0, "R11 irq reset");
        rst_n = 1'b1;
        cable_40w_i = 1'b1;
        idle();
        rdchk(2'd0, 16'h2000, "R10 cable bit");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h80);
        rdchk(2'd1, 16'h0080, "R1 address error bit");
        idle();
        cmp({15'b0, irq_o}, 16'h1, "R4 irq raised");
        tick(1'b1, 2'd1, 2'b01, 16'h0000, 8'h00);
        rdchk(2'd1, 16'h0080, "R2 zero write keeps");
        tick(1'b1, 2'd1, 2'b10, 16'hFF00, 8'h00);
        rdchk(2'd1, 16'hFF80, "R3 mask readback");
        idle();
        cmp({15'b0, irq_o}, 16'h0, "R4 masked quiet");
        tick(1'b1, 2'd1, 2'b01, 16'h0080, 8'h00);
        rdchk(2'd1, 16'hFF00, "R2 w1c clears");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h01);
        tick(1'b1, 2'd1, 2'b01, 16'h0001, 8'h01);
        rdchk(2'd1, 16'hFF01, "R1 event beats clear");
        tick(1'b1, 2'd1, 2'b01, 16'h00FF, 8'h00);
        tick(1'b1, 2'd2, 2'b01, 16'h0009, 8'h00);
        rdchk(2'd2, 16'h0109, "R5 start readback");
        cmp({14'b0, dma_run_o, dma_dir_o}, 16'h3, "R5 run and dir");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h02);
        idle();
        cmp({15'b0, dma_run_o}, 16'h1, "R6 half stays active");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h01);
        idle();
        rdchk(2'd2, 16'h0409, "R6 completion flags");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h80);
        tick(1'b1, 2'd2, 2'b10, 16'h0400, 8'h00);
        rdchk(2'd1, 16'h0080, "R7 mask and linked bits wiped");
        rdchk(2'd2, 16'h0009, "R7 int flag cleared");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'h04);
        rdchk(2'd2, 16'h0209, "R8 bus error flag");
        tick(1'b1, 2'd2, 2'b10, 16'h0200, 8'h00);
        rdchk(2'd2, 16'h0009, "R8 error cleared");
        rdchk(2'd1, 16'h0084, "R8 event bit kept");
        tick(1'b1, 2'd2, 2'b10, 16'h6000, 8'h00);
        rdchk(2'd2, 16'h6009, "R9 capability flags");
        tick(1'b1, 2'd3, 2'b11, 16'hFFFF, 8'h00);
        rdchk(2'd3, 16'h0000, "R12 unmapped read");
        tick(1'b1, 2'd0, 2'b10, 16'h8000, 8'h00);
        cmp({15'b0, soft_rst_o}, 16'h1, "R10 soft pulse high");
        rdchk(2'd1, 16'h0000, "R10 evt cleared");
        rdchk(2'd2, 16'h0000, "R10 dma cleared");
        tick(1'b0, 2'd0, 2'b00, 16'h0, 8'hFF);
        cmp({15'b0, soft_rst_o}, 16'h0, "R10 soft pulse single");
        rdchk(2'd1, 16'h0000, "R10 held in reset");
        tick(1'b1, 2'd0, 2'b10, 16'h0000, 8'h00);
        tick(1'b1, 2'd0, 2'b10, 16'h4000, 8'h00);
        cmp({15'b0, fifo_rst_o}, 16'h1, "R10 fifo pulse high");
        idle();
        cmp({15'b0, fifo_rst_o}, 16'h0, "R10 fifo pulse single");
        tick(1'b1, 2'd0, 2'b10, 16'h0000, 8'h00);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom % 16;
            logic [7:0]  ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            logic [1:0]  be = 2'(($urandom % 3) + 1);
            logic [15:0] wd = 16'($urandom);
            if (r < 8)       tick(1'b0, 2'd0, 2'b00, 16'h0, ev);
            else if (r < 11) tick(1'b1, 2'd1, be, wd, ev);
            else if (r < 14) tick(1'b1, 2'd2, be, wd, ev);
            else if (r == 14)
                tick(1'b1, 2'd0, be, (($urandom % 4) == 0) ? (wd & 16'hC000) : (wd & 16'h4000), ev);
            else             tick(1'b1, 2'd3, be, wd, ev);
            if (m_srst) tick(1'b1, 2'd0, 2'b10, 16'h0000, 8'h00);
            cable_40w_i = ($urandom % 8) != 0;
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule